// File: doc/BRIEF.md
# Two-Stage Delay Timeslot Scheduler

This block is the electronic scheduler for a time slot interchanger whose frame holds N timeslots and whose delay paths come in two banks: short paths of 1 to A−1 slot times and long paths of A, 2A, up to (B−1)·A slot times. With A·B ≥ N, any delay from 0 to N−1 is one long hop followed by one short hop. Always taking the long path first is what keeps two slots from ever colliding inside the interchanger.

Each request carries the absolute index of the slot in which a single-slot burst arrives. The scheduler looks for the smallest delay T whose output slot (arrival + T) mod N is still free. It returns that slot, T, and the two digits of T in base A: the long-path select T / A and the short-path select T mod A. It also returns up to three timed crossbar commands. If every output slot is taken, the burst is discarded.

A one-slot-per-bit occupancy map is kept relative to the current slot. Each slot tick moves it forward by one place, which frees the slot that has just been sent.

Top module: `tsi_sched`

## Requirements
- R1: After reset, grant_valid and discard are 0 and every output slot is free.
- R2: A request is answered in the cycle after it is taken, by either a grant pulse or a discard pulse and never both. On a grant, grant_delay is the smallest T in 0..N−1 for which output slot (req_slot + T) mod N is free, and grant_slot is (req_slot + T) mod N.
- R3: A granted output slot becomes occupied, so a later request cannot be given that slot until it has been sent.
- R4: When all N output slots are occupied, a request produces discard and no grant, and the occupancy is left unchanged.
- R5: On a grant, long_sel = grant_delay / A and short_sel = grant_delay mod A.
- R6: Crossbar port 0 is the external port. Port s (1 ≤ s ≤ A−1) is the short path of length s, and port A−1+k (1 ≤ k ≤ B−1) is the long path of length k·A. Command 0 (bits for index 0 of each cmd_* vector) is the long-path entry. It is valid only when long_sel ≠ 0, and then has offset 0, source port 0 and destination port A−1+long_sel.
- R7: Command 1 is the short-path entry. It is valid only when short_sel ≠ 0, and then has offset long_sel·A and destination port short_sel. Its source is port A−1+long_sel when long_sel ≠ 0, and port 0 otherwise.
- R8: Command 2 is the exit and is valid on every grant, with offset grant_delay and destination port 0. Its source is short_sel when that is nonzero, otherwise A−1+long_sel when long_sel is nonzero, otherwise 0. Invalid commands have all fields 0.
- R9: Each cycle with slot_tick high advances the current slot by one mod N and frees the slot that was current. A slot freed this way can then be granted again as the last slot of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One pulse per timeslot boundary |
| req_valid | input | 1 | Burst request strobe |
| req_slot | input | log2 N | Absolute arrival slot of the burst |
| grant_valid | output | 1 | Grant pulse |
| discard | output | 1 | Discard pulse |
| grant_slot | output | log2 N | Assigned output slot |
| grant_delay | output | log2 N | Total delay T in slots |
| long_sel | output | log2 B | Long-path digit T / A |
| short_sel | output | log2 A | Short-path digit T mod A |
| cmd_vld | output | 3 | Valid bit per command (0 long entry, 1 short entry, 2 exit) |
| cmd_off | output | 3·log2 N | Time offsets, command i in slice i |
| cmd_src | output | 3·log2(A+B−1) | Crossbar input ports |
| cmd_dst | output | 3·log2(A+B−1) | Crossbar output ports |

## Verification
Every grant or discard, together with all of its command fields, appears exactly one clock after the cycle in which the request is taken. The bench therefore drives a request on a falling edge, removes it on the next falling edge and compares all outputs at that same point. Ticks are driven on separate cycles, so the bench model of the slot counter and the occupancy table changes only between requests. Expected delays come from a search over the bench's absolute-slot table, and the commands are derived from the port-numbering rules.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int SLOTS_N    = 16;
    localparam int SHORT_BASE = 4;
    localparam int LONG_CNT   = 4;
    localparam int NUM_CMD    = 3;
    localparam int CMD_LONG   = 0;
    localparam int CMD_SHORT  = 1;
    localparam int CMD_EXIT   = 2;
endpackage

// File: rtl/tsi_slot_map.sv
module tsi_slot_map #(
    parameter int N  = tsi_pkg::SLOTS_N,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mark_en,
    input  logic [SW-1:0] mark_idx,
    output logic [N-1:0]  busy,
    output logic [SW-1:0] cur
);
    typedef struct packed {
        logic [N-1:0]  busy;
        logic [SW-1:0] cur;
    } map_t;

    map_t s_d, s_q;
    logic [N-1:0] b;

    always_comb begin
        s_d = s_q;
        b   = s_q.busy;
        if (mark_en) b[mark_idx] = 1'b1;
        if (tick) begin
            b       = {1'b0, b[N-1:1]};
            s_d.cur = s_q.cur + 1'b1;
        end
        s_d.busy = b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign cur  = s_q.cur;

    // R3: a fresh mark without a tick adds exactly one occupied slot
    a_r3_mark_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && !tick && !busy[mark_idx]) |=> ($countones(busy) == $past($countones(busy)) + 1));

    // R9: a tick with no mark never increases occupancy
    a_r9_tick_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mark_en) |=> ($countones(busy) <= $past($countones(busy))));
endmodule

// File: rtl/tsi_free_finder.sv
module tsi_free_finder #(
    parameter int N  = tsi_pkg::SLOTS_N,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  busy,
    input  logic [SW-1:0] rel,
    output logic          found,
    output logic [SW-1:0] delay
);
    logic [SW-1:0] idx;

    always_comb begin
        found = 1'b0;
        delay = '0;
        idx   = '0;
        for (int t = N - 1; t >= 0; t--) begin
            idx = rel + SW'(t);
            if (!busy[idx]) begin
                found = 1'b1;
                delay = SW'(t);
            end
        end
    end
endmodule

// File: rtl/tsi_delay_split.sv
module tsi_delay_split #(
    parameter int N   = tsi_pkg::SLOTS_N,
    parameter int A   = tsi_pkg::SHORT_BASE,
    parameter int B   = tsi_pkg::LONG_CNT,
    localparam int SW  = $clog2(N),
    localparam int K1W = $clog2(A),
    localparam int K2W = $clog2(B),
    localparam int PW  = $clog2(A + B - 1),
    localparam int NC  = tsi_pkg::NUM_CMD
) (
    input  logic [SW-1:0]    delay,
    output logic [K2W-1:0]   k2,
    output logic [K1W-1:0]   k1,
    output logic [NC-1:0]    vld,
    output logic [NC*SW-1:0] off,
    output logic [NC*PW-1:0] src,
    output logic [NC*PW-1:0] dst
);
    localparam logic [SW-1:0] A_W = SW'(A);
    localparam logic [PW-1:0] LBASE = PW'(A - 1);

    logic [SW-1:0] quo, rem;
    logic [PW-1:0] lport, sport;

    always_comb begin
        quo   = delay / A_W;
        rem   = delay % A_W;
        k2    = quo[K2W-1:0];
        k1    = rem[K1W-1:0];
        lport = LBASE + PW'(k2);
        sport = PW'(k1);
        vld   = '0;
        off   = '0;
        src   = '0;
        dst   = '0;
        if (k2 != '0) begin
            vld[tsi_pkg::CMD_LONG] = 1'b1;
            dst[tsi_pkg::CMD_LONG*PW +: PW] = lport;
        end
        if (k1 != '0) begin
            vld[tsi_pkg::CMD_SHORT] = 1'b1;
            off[tsi_pkg::CMD_SHORT*SW +: SW] = delay - SW'(k1);
            src[tsi_pkg::CMD_SHORT*PW +: PW] = (k2 != '0) ? lport : '0;
            dst[tsi_pkg::CMD_SHORT*PW +: PW] = sport;
        end
        vld[tsi_pkg::CMD_EXIT] = 1'b1;
        off[tsi_pkg::CMD_EXIT*SW +: SW] = delay;
        if (k1 != '0)      src[tsi_pkg::CMD_EXIT*PW +: PW] = sport;
        else if (k2 != '0) src[tsi_pkg::CMD_EXIT*PW +: PW] = lport;
    end
endmodule

// File: rtl/tsi_sched.sv
module tsi_sched #(
    parameter int N   = tsi_pkg::SLOTS_N,
    parameter int A   = tsi_pkg::SHORT_BASE,
    parameter int B   = tsi_pkg::LONG_CNT,
    localparam int SW  = $clog2(N),
    localparam int K1W = $clog2(A),
    localparam int K2W = $clog2(B),
    localparam int PW  = $clog2(A + B - 1),
    localparam int NC  = tsi_pkg::NUM_CMD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             req_valid,
    input  logic [SW-1:0]    req_slot,
    output logic             grant_valid,
    output logic             discard,
    output logic [SW-1:0]    grant_slot,
    output logic [SW-1:0]    grant_delay,
    output logic [K2W-1:0]   long_sel,
    output logic [K1W-1:0]   short_sel,
    output logic [NC-1:0]    cmd_vld,
    output logic [NC*SW-1:0] cmd_off,
    output logic [NC*PW-1:0] cmd_src,
    output logic [NC*PW-1:0] cmd_dst
);
    typedef struct packed {
        logic             grant;
        logic             drop;
        logic [SW-1:0]    slot;
        logic [SW-1:0]    delay;
        logic [K2W-1:0]   k2;
        logic [K1W-1:0]   k1;
        logic [NC-1:0]    vld;
        logic [NC*SW-1:0] off;
        logic [NC*PW-1:0] src;
        logic [NC*PW-1:0] dst;
    } out_t;

    out_t o_d, o_q;

    logic [N-1:0]     busy;
    logic [SW-1:0]    cur, rel, delay;
    logic             found;
    logic [K2W-1:0]   k2;
    logic [K1W-1:0]   k1;
    logic [NC-1:0]    vld;
    logic [NC*SW-1:0] off;
    logic [NC*PW-1:0] src, dst;
    logic             mark_en;

    assign rel     = req_slot - cur;
    assign mark_en = req_valid && found;

    tsi_slot_map #(.N(N)) u_map (
        .clk(clk), .rst_n(rst_n), .tick(slot_tick),
        .mark_en(mark_en), .mark_idx(rel + delay),
        .busy(busy), .cur(cur)
    );

    tsi_free_finder #(.N(N)) u_find (
        .busy(busy), .rel(rel), .found(found), .delay(delay)
    );

    tsi_delay_split #(.N(N), .A(A), .B(B)) u_split (
        .delay(delay), .k2(k2), .k1(k1),
        .vld(vld), .off(off), .src(src), .dst(dst)
    );

    always_comb begin
        o_d = '0;
        if (req_valid) begin
            if (found) begin
                o_d.grant = 1'b1;
                o_d.slot  = req_slot + delay;
                o_d.delay = delay;
                o_d.k2    = k2;
                o_d.k1    = k1;
                o_d.vld   = vld;
                o_d.off   = off;
                o_d.src   = src;
                o_d.dst   = dst;
            end else begin
                o_d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign grant_valid = o_q.grant;
    assign discard     = o_q.drop;
    assign grant_slot  = o_q.slot;
    assign grant_delay = o_q.delay;
    assign long_sel    = o_q.k2;
    assign short_sel   = o_q.k1;
    assign cmd_vld     = o_q.vld;
    assign cmd_off     = o_q.off;
    assign cmd_src     = o_q.src;
    assign cmd_dst     = o_q.dst;

    // R2: a response only follows a request, and grant and discard are exclusive
    a_r2_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || discard) |-> $past(req_valid));
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && discard));
    // R4: a full map answers with discard
    a_r4_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&busy)) |=> discard);
    // R5: the two digits rebuild the delay
    a_r5_digits: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (int'(long_sel) * A + int'(short_sel) == int'(grant_delay)));
    // R8: exit command is always present, timed at the total delay
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (cmd_vld[NC-1] && cmd_off[(NC-1)*SW +: SW] == grant_delay
                         && cmd_dst[(NC-1)*PW +: PW] == '0));
    // R6: long entry valid exactly when a long hop is used
    a_r6_long_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (cmd_vld[0] == (long_sel != '0)));
endmodule

// File: tb/tsi_sched_test.sv
module tsi_sched_test;
    localparam int N = 16;
    localparam int A = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_slot = '0;
    logic        grant_valid, discard;
    logic [3:0]  grant_slot, grant_delay;
    logic [1:0]  long_sel, short_sel;
    logic [2:0]  cmd_vld;
    logic [11:0] cmd_off;
    logic [8:0]  cmd_src, cmd_dst;

    int n_cmp = 0;
    int n_bad = 0;
    int cur = 0;
    bit occ [N];

    always #10 clk = ~clk;

    tsi_sched uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .req_valid(req_valid), .req_slot(req_slot),
        .grant_valid(grant_valid), .discard(discard),
        .grant_slot(grant_slot), .grant_delay(grant_delay),
        .long_sel(long_sel), .short_sel(short_sel),
        .cmd_vld(cmd_vld), .cmd_off(cmd_off),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cur = 0;
        for (int i = 0; i < N; i++) occ[i] = 1'b0;
        check("R1 grant after reset", int'(grant_valid), 0);
        check("R1 discard after reset", int'(discard), 0);
    endtask

    task automatic do_tick();
        @(negedge clk) slot_tick = 1'b1;
        @(negedge clk) slot_tick = 1'b0;
        occ[cur] = 1'b0;
        cur = (cur + 1) % N;
    endtask

    task automatic do_req(input int slot);
        int t_exp = -1;
        int k2, k1, lp, esrc;
        for (int t = N - 1; t >= 0; t--) if (!occ[(slot + t) % N]) t_exp = t;
        @(negedge clk);
        req_valid = 1'b1;
        req_slot  = 4'(slot);
        @(negedge clk);
        req_valid = 1'b0;
        if (t_exp < 0) begin
            check("R4 discard when full", int'(discard), 1);
            check("R4 no grant when full", int'(grant_valid), 0);
            return;
        end
        occ[(slot + t_exp) % N] = 1'b1;
        k2 = t_exp / A;
        k1 = t_exp % A;
        lp = A - 1 + k2;
        esrc = (k1 != 0) ? k1 : ((k2 != 0) ? lp : 0);
        check("R2 grant pulse", int'(grant_valid), 1);
        check("R2 no discard", int'(discard), 0);
        check("R2 delay", int'(grant_delay), t_exp);
        check("R2 slot", int'(grant_slot), (slot + t_exp) % N);
        check("R5 long_sel", int'(long_sel), k2);
        check("R5 short_sel", int'(short_sel), k1);
        check("R6 long vld", int'(cmd_vld[0]), int'(k2 != 0));
        check("R6 long off", int'(cmd_off[3:0]), 0);
        check("R6 long src", int'(cmd_src[2:0]), 0);
        check("R6 long dst", int'(cmd_dst[2:0]), (k2 != 0) ? lp : 0);
        check("R7 short vld", int'(cmd_vld[1]), int'(k1 != 0));
        check("R7 short off", int'(cmd_off[7:4]), (k1 != 0) ? k2 * A : 0);
        check("R7 short src", int'(cmd_src[5:3]), (k1 != 0 && k2 != 0) ? lp : 0);
        check("R7 short dst", int'(cmd_dst[5:3]), k1);
        check("R8 exit vld", int'(cmd_vld[2]), 1);
        check("R8 exit off", int'(cmd_off[11:8]), t_exp);
        check("R8 exit src", int'(cmd_src[8:6]), esrc);
        check("R8 exit dst", int'(cmd_dst[8:6]), 0);
    endtask

    // R2, R3, R5-R8: one arrival slot repeatedly, delays 0..15 in order
    task automatic t_fill_one_slot();
        for (int i = 0; i < N; i++) do_req(5);
        check("R3 last delay", int'(grant_delay), N - 1);
    endtask

    // R4: full map discards and leaves state alone
    task automatic t_full_discard();
        do_req(9);
        do_req(0);
    endtask

    // R9: a tick frees the departed slot, reused as the last slot of the frame
    task automatic t_tick_reuse();
        do_tick();
        do_req(1);
        check("R9 reused slot", int'(grant_slot), 0);
        check("R9 reuse delay", int'(grant_delay), N - 1);
        do_req(1);
        check("R3 reused slot taken", int'(discard), 1);
    endtask

    // R2, R3: scattered arrivals after several ticks
    task automatic t_scattered();
        do_reset();
        do_tick();
        do_tick();
        do_tick();
        do_req(3);
        do_req(2);
        do_req(2);
        do_req(14);
        do_req(13);
        do_req(13);
        do_req(7);
        do_req(6);
    endtask

    initial begin
        do_reset();
        t_fill_one_slot();
        t_full_discard();
        t_tick_reuse();
        t_scattered();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule